// File: doc/BRIEF.md
# Byte-Granular Dirty Tracker for Write-Back Caches

This block sits beside the tag and data arrays of a write-back cache and records, for every line, which bytes have been written since the line was brought in. Each store sets the bits of its byte-enable in the line's mask. When the replacement logic evicts a line, it queries the block. The block returns that line's mask, to be used as the byte-enable of the writeback, and a flag that says whether any byte is dirty. Only modified bytes then travel to the next memory level. When two agents write different bytes of one line, neither agent's writeback can overwrite the bytes the other agent wrote.

A fill or an invalidate of a line empties its mask. A free-running counter records how many evictions found a dirty line. The data array and the victim choice are outside this block. The eviction query is combinational on the stored state, so the cache can form the writeback request in the cycle it picks the victim.

Top module: `dbt_writeback_tracker`

## Requirements
- R1: A store ORs its byte mask into the mask of the addressed line, so bytes written by earlier stores stay set.
- R2: The eviction query returns, in the same cycle, the accumulated mask of the queried line as the writeback byte-enable. Bit k of the mask stands for byte k of the line.
- R3: A fill of a line leaves that line's mask all zero from the next cycle on.
- R4: An invalidate of a line leaves that line's mask all zero from the next cycle on.
- R5: A line is dirty when at least one mask bit is set. A writeback request is raised only for a queried line that is dirty, and never for a clean one.
- R6: The eviction counter increments by one on each cycle with a query of a dirty line. It holds its value on a clean query and when no query is made.
- R7: A store and a fill to the same line in one cycle leave exactly the store's byte mask: the clear happens first, then the store applies.
- R8: A store and an invalidate to the same line in one cycle resolve in the same way as in R7.
- R9: A query returns the state from before any store, fill or invalidate that happens in the same cycle.
- R10: After reset every line is clean and the counter is zero.
- R11: An update to one line does not change the mask of any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store update strobe |
| st_line | input | IDX_W | Line index of the store |
| st_bmask | input | LINE_BYTES | Byte-enable of the store |
| fill_valid | input | 1 | Fill event strobe |
| fill_line | input | IDX_W | Line index being filled |
| inv_valid | input | 1 | Invalidate event strobe |
| inv_line | input | IDX_W | Line index being invalidated |
| ev_valid | input | 1 | Eviction query strobe |
| ev_line | input | IDX_W | Line index being evicted |
| ev_bmask | output | LINE_BYTES | Writeback byte-enable for the queried line |
| ev_dirty | output | 1 | Queried line has at least one dirty byte |
| wb_req | output | 1 | Writeback needed: query valid and line dirty |
| dirty_evict_count | output | CNT_W | Number of dirty evictions since reset |

## Verification
The bench targets the same-cycle collisions. It drives a store together with a fill and then a store together with an invalidate on the same line. A design that applied the clear after the store would lose the new bytes. A design that ignored the clear would keep the old bytes. The bench queries a line in the cycle it is being written, so a design that forwards the new mask into the query fails. It evicts clean lines and checks that neither the writeback request nor the counter moves, which catches a counter that counts every eviction. It also checks that partial stores on neighbouring lines do not leak into each other, and that several stores build up a mask that is not all ones.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

   // Action taken on one line's mask in a cycle
   typedef enum logic [1:0] {
      LN_HOLD      = 2'b00,
      LN_MERGE     = 2'b01,
      LN_CLEAR     = 2'b10,
      LN_CLEAR_SET = 2'b11
   } ln_act_e;

   // Clear has priority in ordering: it empties the mask, then a store lands
   function automatic ln_act_e pick_act(input logic clr, input logic st);
      ln_act_e a;
      case ({clr, st})
         2'b01:   a = LN_MERGE;
         2'b10:   a = LN_CLEAR;
         2'b11:   a = LN_CLEAR_SET;
         default: a = LN_HOLD;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/dbt_line.sv
module dbt_line
   import dbt_pkg::*;
#(
   parameter int LINE_BYTES = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  st,
   input  logic [LINE_BYTES-1:0] bmask,
   output logic [LINE_BYTES-1:0] mask
);

   ln_act_e act;

   always_comb act = pick_act(clr, st);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '0;
      end else begin
         case (act)
            LN_MERGE:     mask <= mask | bmask;
            LN_CLEAR:     mask <= '0;
            LN_CLEAR_SET: mask <= bmask;
            default:      mask <= mask;
         endcase
      end
   end

   // R1: a store without clear keeps old bits and adds its own
   a_r1_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      (st && !clr) |=> (((mask & $past(bmask)) == $past(bmask)) &&
                        ((mask & $past(mask)) == $past(mask))));

   // R3/R4: a clear without a store empties the line
   a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !st) |=> (mask == '0));

   // R7/R8: clear then store leaves exactly the store's bytes
   a_r7_clear_then_set: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && st) |=> (mask == $past(bmask)));

   // R11: untouched line is stable
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !st) |=> $stable(mask));

endmodule

// File: rtl/dbt_evcnt.sv
module dbt_evcnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + ONE;
   end

   // R6: the counter moves by exactly one per dirty eviction, else holds
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> (count == $past(count) + ONE));
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));

endmodule

// File: rtl/dbt_writeback_tracker.sv
module dbt_writeback_tracker #(
   parameter int NUM_LINES  = 16,
   parameter int LINE_BYTES = 16,
   parameter int CNT_W      = 32,
   localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  st_valid,
   input  logic [IDX_W-1:0]      st_line,
   input  logic [LINE_BYTES-1:0] st_bmask,
   input  logic                  fill_valid,
   input  logic [IDX_W-1:0]      fill_line,
   input  logic                  inv_valid,
   input  logic [IDX_W-1:0]      inv_line,
   input  logic                  ev_valid,
   input  logic [IDX_W-1:0]      ev_line,
   output logic [LINE_BYTES-1:0] ev_bmask,
   output logic                  ev_dirty,
   output logic                  wb_req,
   output logic [CNT_W-1:0]      dirty_evict_count
);

   // Elaboration-time parameter checks
   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two, at least 2");
   end
   if (LINE_BYTES < 1) begin : g_bad_bytes
      $error("LINE_BYTES must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [LINE_BYTES-1:0] masks [NUM_LINES];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic hit_st, hit_clr;
      always_comb begin
         hit_st  = st_valid && (st_line == IDX_W'(i));
         hit_clr = (fill_valid && (fill_line == IDX_W'(i))) ||
                   (inv_valid  && (inv_line  == IDX_W'(i)));
      end
      dbt_line #(.LINE_BYTES(LINE_BYTES)) i_line (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (hit_clr),
         .st    (hit_st),
         .bmask (st_bmask),
         .mask  (masks[i])
      );
   end

   // Query reads registered state: same-cycle updates are not visible
   always_comb begin
      ev_bmask = masks[ev_line];
      ev_dirty = |ev_bmask;
      wb_req   = ev_valid && ev_dirty;
   end

   dbt_evcnt #(.CNT_W(CNT_W)) i_evcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (wb_req),
      .count (dirty_evict_count)
   );

   // R5: no writeback without a query
   a_r5_wb_needs_query: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |-> !wb_req);

   // R9: query of a line not written last cycle returns its prior mask
   a_r9_query_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !st_valid && !fill_valid && !inv_valid)
         |=> (masks[$past(ev_line)] == $past(ev_bmask)));

endmodule

// File: tb/test_dbt_writeback_tracker.sv
module test_dbt_writeback_tracker;

   localparam int NL = 16;
   localparam int LB = 16;
   localparam int CW = 32;
   localparam int IW = $clog2(NL);

   logic          clk = 0;
   logic          rst_n = 0;
   logic          st_valid = 0, fill_valid = 0, inv_valid = 0, ev_valid = 0;
   logic [IW-1:0] st_line = 0, fill_line = 0, inv_line = 0, ev_line = 0;
   logic [LB-1:0] st_bmask = 0;
   logic [LB-1:0] ev_bmask;
   logic          ev_dirty, wb_req;
   logic [CW-1:0] dirty_evict_count;

   always #10 clk = ~clk;

   dbt_writeback_tracker #(.NUM_LINES(NL), .LINE_BYTES(LB), .CNT_W(CW)) i_dbt_writeback_tracker (
      .clk, .rst_n, .st_valid, .st_line, .st_bmask, .fill_valid, .fill_line,
      .inv_valid, .inv_line, .ev_valid, .ev_line, .ev_bmask, .ev_dirty,
      .wb_req, .dirty_evict_count
   );

   typedef struct {
      logic [LB-1:0] mask;
      string         req;
   } exp_t;

   exp_t          sb[$];
   logic [LB-1:0] mdl [NL];
   int            exp_cnt = 0;
   int            checks = 0;
   int            errors = 0;

   // Monitor: pops expected query results away from the clock edge
   always @(negedge clk) begin
      if (rst_n && ev_valid) begin
         exp_t e;
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL %s: query with empty scoreboard", "R2");
         end else begin
            e = sb.pop_front();
            if (ev_bmask !== e.mask || ev_dirty !== (e.mask != 0) ||
                wb_req !== (e.mask != 0)) begin
               errors++;
               $display("FAIL %s: mask=%h dirty=%b wb=%b expected mask=%h dirty=%b",
                        e.req, ev_bmask, ev_dirty, wb_req, e.mask, e.mask != 0);
            end
         end
      end
   end

   // Driver: one cycle of stimulus; model applies clear first, then store
   task automatic cyc(input bit s, input int sl, input logic [LB-1:0] bm,
                      input bit f, input int fl, input bit iv, input int il,
                      input bit e, input int el, input string req);
      @(posedge clk); #2;
      st_valid = s;  st_line = IW'(sl); st_bmask = bm;
      fill_valid = f; fill_line = IW'(fl);
      inv_valid = iv; inv_line = IW'(il);
      ev_valid = e;  ev_line = IW'(el);
      if (e) begin
         sb.push_back('{mdl[el], req});
         if (mdl[el] != 0) exp_cnt++;
      end
      if (f)  mdl[fl] = '0;
      if (iv) mdl[il] = '0;
      if (s)  mdl[sl] = mdl[sl] | bm;
   endtask

   task automatic store(input int l, input logic [LB-1:0] bm);
      cyc(1, l, bm, 0, 0, 0, 0, 0, 0, "");
   endtask
   task automatic query(input int l, input string req);
      cyc(0, 0, '0, 0, 0, 0, 0, 1, l, req);
   endtask
   task automatic idle_check_count(input string req);
      @(posedge clk); #2;
      st_valid = 0; fill_valid = 0; inv_valid = 0; ev_valid = 0;
      checks++;
      if (dirty_evict_count !== CW'(exp_cnt)) begin
         errors++;
         $display("FAIL %s: count=%0d expected %0d", req, dirty_evict_count, exp_cnt);
      end
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) mdl[i] = '0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R10: all lines clean after reset, counter zero
      for (int i = 0; i < NL; i++) query(i, "R10");
      idle_check_count("R10");

      // R1, R2: accumulation of partial masks
      store(3, 16'h000F);
      store(3, 16'h0F00);
      store(3, 16'h0003);
      query(3, "R1");
      // R11: neighbours untouched
      store(4, 16'h8000);
      query(2, "R11");
      query(4, "R11");
      query(3, "R2");
      idle_check_count("R6");

      // R3: fill clears
      cyc(0, 0, '0, 1, 3, 0, 0, 0, 0, "");
      query(3, "R3");
      // R4: invalidate clears
      cyc(0, 0, '0, 0, 0, 1, 4, 0, 0, "");
      query(4, "R4");
      // R5, R6: clean evictions move nothing
      idle_check_count("R6");

      // R7: store + fill same line
      store(7, 16'hFF00);
      cyc(1, 7, 16'h0011, 1, 7, 0, 0, 0, 0, "");
      query(7, "R7");
      // R8: store + invalidate same line
      store(8, 16'h00FF);
      cyc(1, 8, 16'h2200, 0, 0, 1, 8, 0, 0, "");
      query(8, "R8");
      // R9: query sees state before same-cycle store
      store(9, 16'h0001);
      cyc(1, 9, 16'h0100, 0, 0, 0, 0, 1, 9, "R9");
      query(9, "R9");
      // R9: query while filled in the same cycle
      cyc(0, 0, '0, 1, 9, 0, 0, 1, 9, "R9");
      query(9, "R5");
      // R11: full-line store on one line, others stay
      store(15, '1);
      query(0, "R11");
      query(15, "R2");
      idle_check_count("R6");

      // Sweep: patterns on every line, evict all
      for (int i = 0; i < NL; i++) if (i % 3 != 0) store(i, LB'(16'h1 << i));
      for (int i = 0; i < NL; i++) query(i, "R5");
      idle_check_count("R6");

      repeat (3) @(posedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R2: %0d queries unobserved, expected 0", sb.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule